// File: doc/BRIEF.md
# Region-Protected Memory Controller

A front end for a 4096-word by 18-bit memory. The 12-bit address space is divided into four equal regions of 1024 words. Each region has an access mode set by a static configuration input that behaves like a bank of jumper wires. The mode is read/write, read-only, or protected. A write into a protected region takes effect only after the processor has issued a write-unlock pulse. That unlock covers exactly one protected write.

Reads are allowed in every mode. Every strobe is answered by a one-cycle ready pulse in the following cycle, including strobes that are refused. A refused write leaves the memory untouched and raises a one-cycle violation flag at the same time as its ready pulse. The usual configuration protects the lower half of memory (regions 0 and 1) and leaves the upper half read/write.

Top module: `prot_mem_ctrl`

## Requirements
- R1: The store holds 4096 words of 18 bits addressed by `addr_i[11:0]`. Bits `addr_i[11:10]` pick the region, and region r takes its mode from `region_mode_i[2r+1:2r]`.
- R2: The mode codes are 2'b00 read/write, 2'b01 read-only, and 2'b10 or 2'b11 protected.
- R3: A read is allowed in every mode. `rdata_o` shows the addressed word in the cycle after `rd_i` and holds its value when no read is accepted.
- R4: A write to a read/write region stores `wdata_i` and never raises `violation_o`.
- R5: A write to a read-only region leaves memory unchanged and sets `violation_o` for exactly one cycle, in the cycle after the strobe.
- R6: A write to a protected region with no armed unlock leaves memory unchanged and sets `violation_o` for one cycle. `violation_o` is never set in a cycle that does not follow a write strobe.
- R7: An `unlock_i` pulse arms a single protected write, however many cycles later that write arrives. The write that uses the unlock disarms it, so the next protected write needs a new pulse. An `unlock_i` pulse in the same cycle as a protected write does not apply to that write, but it leaves the unlock armed for the next one.
- R8: Writes to read/write regions and refused writes to read-only regions do not use up an armed unlock.
- R9: Each cycle with `rd_i` or `wr_i` high is followed by exactly one cycle of `ready_o` high. This includes refused writes. `ready_o` is low after a cycle with no strobe.
- R10: When `rd_i` and `wr_i` are high together, only the write is performed and `rdata_o` keeps its previous value.
- R11: Reset clears `ready_o`, `violation_o` and `rdata_o` and disarms any pending unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| region_mode_i | input | 8 | Static per-region mode, 2 bits per region |
| addr_i | input | 12 | Word address |
| wdata_i | input | 18 | Write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| unlock_i | input | 1 | One-shot write-unlock command |
| rdata_o | output | 18 | Read data, valid the cycle after a read |
| ready_o | output | 1 | Access completed |
| violation_o | output | 1 | Refused write |

## Verification
A stuck or wrongly cleared unlock flag is detected at the ports on the next protected write. If the flag stays armed, a second protected write is accepted and `violation_o` stays low. If the flag clears early, a write after an unrelated read/write or read-only write is refused. In both cases the error shows one cycle after the write strobe, and the bench then reads the word back to confirm the fault. A refused write that still modifies memory is exposed by the read-back one cycle later. A wrong region decode shows as a violation flag on the wrong side of the boundary at address 0x7FF.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  localparam int unsigned ADDR_W      = 12;
  localparam int unsigned DATA_W      = 18;
  localparam int unsigned REGION_BITS = 2;
  localparam int unsigned NUM_REGIONS = 1 << REGION_BITS;
  localparam int unsigned MODE_W      = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_RW     = 2'b00,
    MODE_RO     = 2'b01,
    MODE_PROT   = 2'b10,
    MODE_PROT_X = 2'b11
  } region_mode_e;
endpackage

// File: rtl/rpm_access_check.sv
module rpm_access_check
  import rpm_pkg::*;
(
  input  region_mode_e mode_i,
  input  logic         wr_i,
  input  logic         armed_i,
  output logic         wr_grant_o,
  output logic         wr_block_o,
  output logic         consume_o
);
  logic is_prot;

  always_comb begin
    is_prot    = (mode_i == MODE_PROT) || (mode_i == MODE_PROT_X);
    wr_grant_o = 1'b0;
    wr_block_o = 1'b0;
    consume_o  = 1'b0;
    if (wr_i) begin
      unique case (mode_i)
        MODE_RW: wr_grant_o = 1'b1;
        MODE_RO: wr_block_o = 1'b1;
        default: begin
          wr_grant_o = armed_i;
          wr_block_o = !armed_i;
          consume_o  = armed_i;
        end
      endcase
    end
  end

  always_comb begin
    assert (!(wr_grant_o && wr_block_o)); // R6
    assert (!consume_o || is_prot);       // R8
  end
endmodule

// File: rtl/rpm_unlock.sv
module rpm_unlock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic unlock_i,
  input  logic consume_i,
  output logic armed_o
);
  logic armed_q;

  // A fresh pulse wins over consumption in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (unlock_i)  armed_q <= 1'b1;
    else if (consume_i) armed_q <= 1'b0;
  end

  assign armed_o = armed_q;

  AST_UNLOCK_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_i |=> armed_o); // R7
  AST_UNLOCK_SPENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !unlock_i) |=> !armed_o); // R7
  AST_UNLOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!consume_i && !unlock_i) |=> $stable(armed_o)); // R8
endmodule

// File: rtl/rpm_store.sv
module rpm_store #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R3
endmodule

// File: rtl/prot_mem_ctrl.sv
module prot_mem_ctrl
  import rpm_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_REGIONS*MODE_W-1:0] region_mode_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DW-1:0]                 wdata_i,
  input  logic                          rd_i,
  input  logic                          wr_i,
  input  logic                          unlock_i,
  output logic [DW-1:0]                 rdata_o,
  output logic                          ready_o,
  output logic                          violation_o
);
  localparam int unsigned REG_LSB = AW - REGION_BITS;

  region_mode_e region_mode [NUM_REGIONS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_mode
    assign region_mode[r] = region_mode_e'(region_mode_i[r*MODE_W +: MODE_W]);
  end

  logic [REGION_BITS-1:0] region_sel;
  region_mode_e           mode_sel;
  logic                   armed;
  logic                   wr_grant;
  logic                   wr_block;
  logic                   consume;
  logic                   rd_go;
  logic                   ready_q;
  logic                   viol_q;

  assign region_sel = addr_i[AW-1:REG_LSB];
  assign mode_sel   = region_mode[region_sel];
  assign rd_go      = rd_i && !wr_i;

  rpm_access_check i_check (
    .mode_i     (mode_sel),
    .wr_i       (wr_i),
    .armed_i    (armed),
    .wr_grant_o (wr_grant),
    .wr_block_o (wr_block),
    .consume_o  (consume)
  );

  rpm_unlock i_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unlock_i  (unlock_i),
    .consume_i (consume),
    .armed_o   (armed)
  );

  rpm_store #(.ADDR_W(AW), .DATA_W(DW)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_grant),
    .re_i    (rd_go),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      ready_q <= rd_i || wr_i;
      viol_q  <= wr_block;
    end
  end

  assign ready_o     = ready_q;
  assign violation_o = viol_q;

  AST_RO_WRITE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mode_sel == MODE_RO) |=> violation_o); // R5
  AST_RW_WRITE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mode_sel == MODE_RW) |=> !violation_o); // R4
  AST_PROT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mode_sel[1] && !armed) |=> violation_o); // R6
  AST_VIOL_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !violation_o); // R6
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) |=> ready_o); // R9
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |=> !ready_o); // R9
  AST_BOTH_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i) |=> $stable(rdata_o)); // R10
endmodule

// File: tb/test_prot_mem_ctrl.sv
module test_prot_mem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg;
  logic [11:0] addr;
  logic [17:0] wdata;
  logic        rd, wr, unl;
  logic [17:0] rdata;
  logic        ready, viol;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prot_mem_ctrl i_prot_mem_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .region_mode_i(cfg), .addr_i(addr),
    .wdata_i(wdata), .rd_i(rd), .wr_i(wr), .unlock_i(unl),
    .rdata_o(rdata), .ready_o(ready), .violation_o(viol)
  );

  typedef struct packed {
    logic        rd, wr, unl;
    logic [11:0] addr;
    logic [17:0] wdata;
    logic        e_rdy, e_vio, chk_rd;
    logic [17:0] e_rdata;
  } vec_t;

  // cfg for table: region3 RO, region2 RW, regions 1/0 protected
  localparam logic [7:0] CFG_TBL = 8'b01_00_10_10;
  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b1,12'h000,18'h00000,1'b0,1'b0,1'b0,18'h00000}, // R7 arm
    '{1'b0,1'b1,1'b0,12'h011,18'h01111,1'b1,1'b0,1'b0,18'h00000}, // R7 use
    '{1'b0,1'b1,1'b0,12'h011,18'h3FFFF,1'b1,1'b1,1'b0,18'h00000}, // R7 spent
    '{1'b1,1'b0,1'b0,12'h011,18'h00000,1'b1,1'b0,1'b1,18'h01111}, // R6 unchanged
    '{1'b0,1'b1,1'b0,12'h800,18'h12345,1'b1,1'b0,1'b0,18'h00000}, // R4
    '{1'b1,1'b0,1'b0,12'h800,18'h00000,1'b1,1'b0,1'b1,18'h12345}, // R3
    '{1'b0,1'b1,1'b0,12'h010,18'h00AAA,1'b1,1'b1,1'b0,18'h00000}, // R6
    '{1'b0,1'b0,1'b1,12'h000,18'h00000,1'b0,1'b0,1'b0,18'h00000}, // R7 arm
    '{1'b0,1'b1,1'b0,12'h801,18'h00055,1'b1,1'b0,1'b0,18'h00000}, // R8 rw
    '{1'b0,1'b1,1'b0,12'hC01,18'h00001,1'b1,1'b1,1'b0,18'h00000}, // R8 ro
    '{1'b0,1'b1,1'b0,12'h010,18'h00AAA,1'b1,1'b0,1'b0,18'h00000}, // R8 still armed
    '{1'b1,1'b0,1'b0,12'h010,18'h00000,1'b1,1'b0,1'b1,18'h00AAA}, // R7
    '{1'b1,1'b0,1'b0,12'h801,18'h00000,1'b1,1'b0,1'b1,18'h00055}, // R4
    '{1'b0,1'b0,1'b0,12'h000,18'h00000,1'b0,1'b0,1'b1,18'h00055}, // R9 idle, R3 hold
    '{1'b1,1'b1,1'b0,12'h800,18'h0F0F0,1'b1,1'b0,1'b1,18'h00055}, // R10
    '{1'b1,1'b0,1'b0,12'h800,18'h00000,1'b1,1'b0,1'b1,18'h0F0F0}, // R10 write done
    '{1'b0,1'b1,1'b1,12'h012,18'h00002,1'b1,1'b1,1'b0,18'h00000}, // R7 same cycle
    '{1'b0,1'b1,1'b0,12'h012,18'h00222,1'b1,1'b0,1'b0,18'h00000}, // R7 armed after
    '{1'b1,1'b0,1'b0,12'h012,18'h00000,1'b1,1'b0,1'b1,18'h00222}, // R7
    '{1'b0,1'b1,1'b0,12'h7FF,18'h00123,1'b1,1'b1,1'b0,18'h00000}, // R1 boundary prot
    '{1'b0,1'b1,1'b0,12'h800,18'h00321,1'b1,1'b0,1'b0,18'h00000}  // R1 boundary rw
  };

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic r, input logic w, input logic u,
                    input logic [11:0] a, input logic [17:0] d);
    @(negedge clk);
    rd = r; wr = w; unl = u; addr = a; wdata = d;
    @(posedge clk);
    #1;
    rd = 1'b0; wr = 1'b0; unl = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg = CFG_TBL; addr = '0; wdata = '0; rd = 0; wr = 0; unl = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 ready", {17'd0, ready}, 18'd0);
    chk("R11 violation", {17'd0, viol}, 18'd0);
    chk("R11 rdata", rdata, 18'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op(TBL[i].rd, TBL[i].wr, TBL[i].unl, TBL[i].addr, TBL[i].wdata);
      chk($sformatf("R9 ready vec %0d", i), {17'd0, ready}, {17'd0, TBL[i].e_rdy});
      chk($sformatf("R5/R6 violation vec %0d", i), {17'd0, viol}, {17'd0, TBL[i].e_vio});
      if (TBL[i].chk_rd) chk($sformatf("R3 rdata vec %0d", i), rdata, TBL[i].e_rdata);
    end
    op(1'b1, 1'b0, 1'b0, 12'h7FF, 18'h0);
    chk("R1 refused 0x7FF unchanged", {17'd0, rdata == 18'h00123}, 18'd0);
    op(1'b1, 1'b0, 1'b0, 12'h800, 18'h0);
    chk("R1 0x800 written", rdata, 18'h00321);

    // R5: read-only region keeps its content; reads allowed there
    cfg = 8'b00_00_10_10;
    op(1'b0, 1'b1, 1'b0, 12'hC00, 18'h00777);
    cfg = 8'b01_00_10_10;
    op(1'b0, 1'b1, 1'b0, 12'hC00, 18'h3FFFF);
    chk("R5 violation", {17'd0, viol}, 18'd1);
    op(1'b1, 1'b0, 1'b0, 12'hC00, 18'h0);
    chk("R5 violation one cycle", {17'd0, viol}, 18'd0);
    chk("R5 R3 ro read unchanged", rdata, 18'h00777);

    // R2: code 2'b11 behaves as protected
    cfg = 8'b11_00_10_10;
    op(1'b0, 1'b1, 1'b0, 12'hC02, 18'h00009);
    chk("R2 code 11 locked", {17'd0, viol}, 18'd1);
    op(1'b0, 1'b0, 1'b1, 12'h000, 18'h0);
    op(1'b0, 1'b1, 1'b0, 12'hC02, 18'h00009);
    chk("R2 code 11 unlocked", {17'd0, viol}, 18'd0);
    op(1'b1, 1'b0, 1'b0, 12'hC02, 18'h0);
    chk("R2 code 11 data", rdata, 18'h00009);

    // R11: reset disarms a pending unlock
    cfg = CFG_TBL;
    op(1'b0, 1'b0, 1'b1, 12'h000, 18'h0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R11 rdata cleared", rdata, 18'd0);
    op(1'b0, 1'b1, 1'b0, 12'h020, 18'h00ABC);
    chk("R11 unlock disarmed", {17'd0, viol}, 18'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule